// File: doc/BRIEF.md
# Serial Calendar Clock Command Shifter

This block is the host-facing side of a bit-banged calendar clock link. Software toggles three bits in an 8-bit control register, a command strobe, a serial clock and a serial data-in bit, next to a 3-bit command field. Each bus write is compared with the control value already held, and the falling edges found this way drive the link. No separate clock domain is involved.

A falling strobe latches a command taken from the command field of the control value written before it. A read command copies a packed BCD snapshot of the current time into a 52-bit output shift register. The time fields arrive in binary on input buses, and the block does the BCD conversion itself. An extended command takes its real code from a 4-bit register that software fills one bit per serial clock. Every falling serial clock shifts the output register right by one, and the output bit shows on a status port. A separate mode register chooses whether the time word is padded with four leading zero bits.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset the mode readback is 0xFF, the status port reads 0xF8, and the control register and the serial command register hold 0.
- R2: A write with `wr_sel`=1 stores `wr_data` in the mode register, which reads back on `mode_q` in the next cycle. Control writes (`wr_sel`=0) leave the mode register unchanged.
- R3: A control write that clears bit 3 while the held control value has bit 3 set is a strobe fall. If bits 2:0 of the held value equal 3, the time snapshot is loaded. Bits 2:0 of the newly written value play no part in this decision.
- R4: The snapshot word holds, from bit 0 upward: BCD seconds [7:0], BCD minutes [15:8], BCD hours [23:16], BCD day of month [31:24], binary weekday [35:32], binary month [39:36] and BCD two-digit year [47:40].
- R5: When mode bit 5 is set, the loaded word is the snapshot shifted left by 4, so the first four bits out are 0. When the bit is clear, the snapshot sits at bit 0.
- R6: A control write that clears bit 4 while the held value has bit 4 set is a clock fall. It shifts the output register right by one and fills the top with 0. `status_q` is 0xF8 ORed with output register bit 0.
- R7: On a clock fall, bit 5 of the held control value enters the serial command register at its top (bit 3) as the other bits move down. After data bits d0, d1, d2, d3 the register holds {d3,d2,d1,d0}.
- R8: On a strobe fall with held command 7, the effective command is the serial command register. The snapshot loads only when that register equals 3.
- R9: Held commands other than 3 and 7, a strobe that rises or stays put, and a serial clock that rises or stays put all leave the output register unchanged.
- R10: When a single write makes both a strobe fall and a clock fall, the snapshot is loaded first and then shifted once. The serial command register takes its value before the shift for the extended decision.
- R11: Seconds, minutes, hours, day and year inputs from 0 to 99 convert to two BCD digits, tens in the upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control register, 1 mode register |
| wr_data | input | 8 | Write data |
| sec_bin | input | 7 | Seconds, binary 0 to 59 |
| min_bin | input | 7 | Minutes, binary 0 to 59 |
| hour_bin | input | 5 | Hours, binary 0 to 23 |
| mday_bin | input | 5 | Day of month, binary 1 to 31 |
| wday_bin | input | 3 | Weekday, binary 0 to 6 |
| month_bin | input | 4 | Month, binary 1 to 12 |
| year_bin | input | 7 | Two-digit year, binary 0 to 99 |
| mode_q | output | 8 | Mode register readback |
| status_q | output | 8 | 0xF8 ORed with the current output bit |

## Verification
The hardest state to reach is an extended read, because the serial command register can only be filled through clock falls. Those same falls also shift the output register. The bench clocks in the pattern 1,1,0,0 with the data bit set up on the rising write, issues command 7, and then drains all 52 bits to compare them with the packed word it computes. A pattern of 5 follows and must not load. The bench also produces the combined strobe-and-clock fall in one write, and it checks that a non-read command written in the new value is ignored. A behavioural model tracks every register and is compared on both outputs after each cycle.

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int DW         = 8,
  parameter int BODY_W     = 48,
  parameter int PAD_W      = 4,
  parameter int STB_BIT    = 3,
  parameter int SCK_BIT    = 4,
  parameter int SDI_BIT    = 5,
  parameter int PAD_EN_BIT = 5,
  parameter int RD_CODE    = 3,
  parameter int EXT_CODE   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [6:0]    sec_bin,
  input  logic [6:0]    min_bin,
  input  logic [4:0]    hour_bin,
  input  logic [4:0]    mday_bin,
  input  logic [2:0]    wday_bin,
  input  logic [3:0]    month_bin,
  input  logic [6:0]    year_bin,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] status_q
);
  localparam int SH_W = BODY_W + PAD_W;

  function automatic logic [7:0] bcd8(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  logic [DW-1:0]   ctrl_q;
  logic [3:0]      scmd_q;
  logic [SH_W-1:0] sh_q;

  wire ctrl_wr  = wr_en & ~wr_sel;
  wire stb_fall = ctrl_wr & ctrl_q[STB_BIT] & ~wr_data[STB_BIT];
  wire sck_fall = ctrl_wr & ctrl_q[SCK_BIT] & ~wr_data[SCK_BIT];

  wire [3:0] eff_cmd = (ctrl_q[2:0] == 3'(EXT_CODE)) ? scmd_q : {1'b0, ctrl_q[2:0]};
  wire       load    = stb_fall & (eff_cmd == 4'(RD_CODE));

  wire [BODY_W-1:0] body = {bcd8(year_bin), month_bin, 1'b0, wday_bin,
                            bcd8({2'b00, mday_bin}), bcd8({2'b00, hour_bin}),
                            bcd8(min_bin), bcd8(sec_bin)};
  wire [SH_W-1:0] snap = mode_q[PAD_EN_BIT] ? {body, {PAD_W{1'b0}}}
                                            : {{PAD_W{1'b0}}, body};

  wire [SH_W-1:0] sh_base = load ? snap : sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '1;
      ctrl_q <= '0;
      scmd_q <= '0;
      sh_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel) mode_q <= wr_data;
      else begin
        ctrl_q <= wr_data;
        sh_q   <= sck_fall ? (sh_base >> 1) : sh_base;
        if (sck_fall) scmd_q <= {ctrl_q[SDI_BIT], scmd_q[3:1]};
      end
    end
  end

  assign status_q = {{(DW-1){1'b1}}, 1'b0} & 8'hF8 | {{(DW-1){1'b0}}, sh_q[0]};

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sh_q) && $stable(scmd_q) && $stable(mode_q));

  assert_no_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !stb_fall && !sck_fall) |=> $stable(sh_q) && $stable(scmd_q));

  assert_shift_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !stb_fall) |=> status_q[0] == $past(sh_q[1]) && sh_q[SH_W-1] == 1'b0);

  assert_serial_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> scmd_q[3] == $past(ctrl_q[SDI_BIT]));

  assert_mode_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(mode_q));

  assert_ctrl_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(ctrl_q) && $stable(sh_q));

  assert_status_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:3] == 5'h1F && status_q[2:1] == 2'b00);
endmodule

// File: tb/rtc_serial_port_tb.sv
`timescale 1ns/1ps
module rtc_serial_port_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] sec_bin = 0, min_bin = 0, year_bin = 0;
  logic [4:0] hour_bin = 0, mday_bin = 1;
  logic [2:0] wday_bin = 0;
  logic [3:0] month_bin = 1;
  logic [7:0] mode_q, status_q;

  always #4 clk = ~clk;

  rtc_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_bin(sec_bin), .min_bin(min_bin), .hour_bin(hour_bin), .mday_bin(mday_bin),
    .wday_bin(wday_bin), .month_bin(month_bin), .year_bin(year_bin),
    .mode_q(mode_q), .status_q(status_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mode, m_ctrl, m_scmd;
  longint unsigned m_sh;

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned bcd(input int v);
    return longint'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic longint unsigned exp_word(input int mode);
    longint unsigned w;
    w = bcd(int'(sec_bin)) + (bcd(int'(min_bin)) << 8) + (bcd(int'(hour_bin)) << 16)
      + (bcd(int'(mday_bin)) << 24) + (longint'(wday_bin) << 32)
      + (longint'(month_bin) << 36) + (bcd(int'(year_bin)) << 40);
    if ((mode / 32) % 2 == 1) w = w * 16;
    return w;
  endfunction

  task automatic model_write(input bit sel, input int d);
    int cmd;
    if (sel) begin
      m_mode = d;
      return;
    end
    if ((m_ctrl & 8) != 0 && (d & 8) == 0) begin
      cmd = m_ctrl % 8;
      if (cmd == 7) cmd = m_scmd;
      if (cmd == 3) m_sh = exp_word(m_mode);
    end
    if ((m_ctrl & 16) != 0 && (d & 16) == 0) begin
      m_scmd = m_scmd / 2 + (((m_ctrl & 32) != 0) ? 8 : 0);
      m_sh = m_sh / 2;
    end
    m_ctrl = d;
  endtask

  task automatic compare_model();
    check(mode_q == 8'(m_mode), "R2 model mode", mode_q, longint'(m_mode));
    check(status_q == (8'hF8 | 8'(m_sh % 2)), "R6 model status", status_q,
          longint'(8'hF8 | 8'(m_sh % 2)));
  endtask

  task automatic wr(input bit sel, input int d);
    wr_en = 1; wr_sel = sel; wr_data = 8'(d);
    model_write(sel, d);
    @(negedge clk);
    wr_en = 0;
    compare_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_model();
    end
  endtask

  task automatic drain(input int n, output longint unsigned v);
    v = 0;
    for (int i = 0; i < n; i++) begin
      if (status_q[0]) v = v | (longint'(1) << i);
      wr(0, 8'h10);
      wr(0, 8'h00);
    end
  endtask

  task automatic serial_in(input int b);
    wr(0, 8'h10 | (b << 5));
    wr(0, 8'h00);
  endtask

  task automatic direct_read();
    wr(0, 8'h0B);
    wr(0, 8'h00);
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dd,
                          input int wd, input int mo, input int y);
    sec_bin = 7'(s); min_bin = 7'(mi); hour_bin = 5'(h); mday_bin = 5'(dd);
    wday_bin = 3'(wd); month_bin = 4'(mo); year_bin = 7'(y);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned v;
    m_mode = 255; m_ctrl = 0; m_scmd = 0; m_sh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(mode_q == 8'hFF, "R1 reset mode", mode_q, 64'hFF);
    check(status_q == 8'hF8, "R1 reset status", status_q, 64'hF8);
    // R1: held control is 0, so dropping strobe after reset loads nothing
    set_time(45, 7, 23, 31, 6, 12, 99);
    wr(0, 8'h03);
    check(status_q == 8'hF8, "R1 no stale strobe", status_q, 64'hF8);

    wr(1, 8'h00);
    check(mode_q == 8'h00, "R2 mode write", mode_q, 0);
    wr(0, 8'hFF); wr(0, 8'h00);
    check(mode_q == 8'h00, "R2 ctrl write keeps mode", mode_q, 0);
    drain(52, v);

    direct_read();
    drain(52, v);
    check(v == exp_word(0), "R3 R4 direct read unpadded", v, exp_word(0));

    wr(1, 8'h20);
    direct_read();
    drain(52, v);
    check(v == exp_word(32), "R5 padded read", v, exp_word(32));
    check((v & 64'hF) == 0, "R5 four leading zeros", v & 64'hF, 0);

    wr(1, 8'h00);
    // R3: strobe falls with held command 0, new value carries 3
    wr(0, 8'h08); wr(0, 8'h03);
    check(status_q[0] == 1'b0, "R3 new command ignored", status_q, 64'hF8);
    wr(0, 8'h00);
    // R9: other commands, rising and steady edges
    wr(0, 8'h0D); wr(0, 8'h05);
    check(status_q == 8'hF8, "R9 command 5 ignored", status_q, 64'hF8);
    direct_read();
    wr(0, 8'h18); wr(0, 8'h18); wr(0, 8'h00);
    drain(52, v);
    check(v == (exp_word(0) >> 1), "R9 R10 held high then both fall", v, exp_word(0) >> 1);
    idle(4);

    // R7 R8: extended path with serial value 3 (bits 1,1,0,0)
    serial_in(1); serial_in(1); serial_in(0); serial_in(0);
    wr(0, 8'h0F); wr(0, 8'h00);
    drain(52, v);
    check(v == exp_word(0), "R7 R8 extended read", v, exp_word(0));

    // R8: serial value 5 must not load
    serial_in(1); serial_in(0); serial_in(1); serial_in(0);
    wr(0, 8'h0F); wr(0, 8'h00);
    check(status_q == 8'hF8, "R8 extended non-read", status_q, 64'hF8);
    drain(52, v);
    check(v == 0, "R8 nothing loaded", v, 0);

    // R10: both edges in one write
    wr(0, 8'h1B); wr(0, 8'h00);
    drain(51, v);
    check(v == (exp_word(0) >> 1), "R10 combined fall", v, exp_word(0) >> 1);

    // R11: BCD corners
    set_time(0, 9, 10, 1, 0, 1, 0);
    direct_read(); drain(52, v);
    check(v == exp_word(0), "R11 low digits", v, exp_word(0));
    set_time(59, 59, 23, 19, 3, 9, 99);
    direct_read(); drain(52, v);
    check(v == exp_word(0), "R11 high digits", v, exp_word(0));
    set_time(99, 90, 20, 30, 5, 10, 50);
    wr(1, 8'h20);
    direct_read(); drain(52, v);
    check(v == exp_word(32), "R11 R5 padded 99", v, exp_word(32));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule